// File: doc/BRIEF.md
# Progressive Random-Access Scan Grid

This block holds a chip's test-accessible state bits in a grid of rows and columns instead of a serial shift chain. In functional mode every cell is an ordinary D flip-flop that takes its own functional input on every clock. In test mode the cells keep their values unless an access reaches them. A capture strobe loads the whole grid from the functional inputs in one cycle. For single-cell access, a row pointer steps through the rows in a fixed order, and a column address picks one cell of the current row. That cell can be written through a valid/ready write channel, and its value is visible on the read port in the same cycle.

The test flow alternates between the two kinds of access for each vector. A tester writes stimulus bits row by row and reads back captured response bits. A write or read touches exactly one cell, so the other cells keep their values.

Write channel rules: a write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high in test mode, except in a cycle where `capture` is high. A source that sees `wr_ready` low keeps `wr_valid`, `wr_data` and `col_addr` stable until the write is accepted. The read side has no back-pressure. `rd_data` follows the address combinationally, and `rd_valid` qualifies it.

Top module: `pras_grid`

## Requirements
- R1: While `rst_n` is low, every cell and the row pointer are cleared to 0.
- R2: With `test_mode` low, `fun_q` equals the `fun_d` value from the previous clock edge. Bit r*COLS+c of both vectors is the cell at row r, column c.
- R3: With `test_mode` low, `wr_ready` is 0, writes have no effect, and the row pointer is 0 after the next edge.
- R4: In test mode, with no capture and no accepted write, every cell keeps its value.
- R5: In test mode, `capture` high loads every cell from `fun_d` at the next edge. During that cycle `wr_ready` is 0, so capture takes priority over a write.
- R6: In test mode, `row_step` advances `active_row` by one at the next edge, and it wraps from ROWS-1 to 0.
- R7: An accepted write stores `wr_data` into the cell at (`active_row`, `col_addr`) only. All other cells are unchanged.
- R8: In test mode, with `col_addr` < COLS, `rd_valid` is 1 and `rd_data` equals the cell at (`active_row`, `col_addr`) in the same cycle.
- R9: A `col_addr` of COLS or more is out of range. A write there changes no cell, and `rd_valid` and `rd_data` are 0.
- R10: A write accepted in the same cycle as `row_step` goes to the row that was active before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | 1 selects test access, 0 selects functional flip-flop mode |
| fun_d | input | ROWS*COLS | Functional data inputs, one per cell |
| fun_q | output | ROWS*COLS | Cell outputs, one per cell |
| capture | input | 1 | Test-mode strobe that loads all cells from fun_d |
| row_step | input | 1 | Advances the row pointer |
| active_row | output | clog2(ROWS) | Currently enabled row |
| col_addr | input | clog2(COLS) | Column of the addressed cell |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted |
| wr_data | input | 1 | Bit to write |
| rd_valid | output | 1 | rd_data is a real cell value |
| rd_data | output | 1 | Value of the addressed cell |

## Verification
The read outputs (`rd_data`, `rd_valid`, `wr_ready`) are combinational and are due in the same cycle as the address and mode. The bench checks them one time unit after it drives the inputs, before the next edge. Cell contents on `fun_q` and the row pointer are due one edge after the stimulus. The driver pushes its expectation for every cycle it drives into a queue. The monitor pops that expectation one time unit after the following rising edge, so each expectation is compared in exactly the cycle its result is due.

// File: rtl/pras_pkg.sv
package pras_pkg;
  typedef enum logic [1:0] {
    CELL_HOLD   = 2'd0,
    CELL_LOAD_D = 2'd1,
    CELL_LOAD_W = 2'd2
  } cell_op_e;

  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pras_cell.sv
module pras_cell (
  input  logic               clk,
  input  logic               rst_n,
  input  pras_pkg::cell_op_e op,
  input  logic               d,
  input  logic               w,
  output logic               q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else begin
      case (op)
        pras_pkg::CELL_LOAD_D: q <= d;
        pras_pkg::CELL_LOAD_W: q <= w;
        default:               q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pras_row_seq.sv
module pras_row_seq #(
  parameter int ROWS = 4,
  parameter int RW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          step,
  output logic [RW-1:0] row
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !test_mode) row <= '0;
    else if (step)            row <= (row == LAST) ? '0 : row + 1'b1;
  end
endmodule

// File: rtl/pras_col_dec.sv
module pras_col_dec #(
  parameter int COLS = 8,
  parameter int CW   = 3
) (
  input  logic [CW-1:0]   col_addr,
  output logic [COLS-1:0] col_sel,
  output logic            in_range
);
  assign in_range = (int'(col_addr) < COLS);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = (col_addr == CW'(c));
  end
endmodule

// File: rtl/pras_grid.sv
module pras_grid #(
  parameter  int ROWS  = 4,
  parameter  int COLS  = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int RW    = pras_pkg::addr_bits(ROWS),
  localparam int CW    = pras_pkg::addr_bits(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic [CELLS-1:0] fun_d,
  output logic [CELLS-1:0] fun_q,
  input  logic             capture,
  input  logic             row_step,
  output logic [RW-1:0]    active_row,
  input  logic [CW-1:0]    col_addr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_data,
  output logic             rd_valid,
  output logic             rd_data
);
  logic [COLS-1:0] col_sel;
  logic            col_ok;
  logic [ROWS-1:0] row_sel;
  logic            wr_fire;
  logic            load_all;

  pras_row_seq #(.ROWS(ROWS), .RW(RW)) u_rows (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .step(row_step), .row(active_row)
  );

  pras_col_dec #(.COLS(COLS), .CW(CW)) u_cols (
    .col_addr(col_addr), .col_sel(col_sel), .in_range(col_ok)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_rsel
    assign row_sel[r] = (active_row == RW'(r));
  end

  assign load_all = !test_mode || capture;
  assign wr_ready = test_mode && !capture;
  assign wr_fire  = wr_valid && wr_ready && col_ok;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      pras_pkg::cell_op_e op;
      always_comb begin
        if (load_all)                              op = pras_pkg::CELL_LOAD_D;
        else if (wr_fire && row_sel[r] && col_sel[c]) op = pras_pkg::CELL_LOAD_W;
        else                                       op = pras_pkg::CELL_HOLD;
      end
      pras_cell u_cell (
        .clk(clk), .rst_n(rst_n), .op(op),
        .d(fun_d[r*COLS + c]), .w(wr_data), .q(fun_q[r*COLS + c])
      );
    end
  end

  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < CELLS; i++)
      hit = hit | (fun_q[i] & row_sel[i / COLS] & col_sel[i % COLS]);
    rd_valid = test_mode && col_ok;
    rd_data  = rd_valid && hit;
  end
endmodule

// File: rtl/pras_grid_chk.sv
module pras_grid_chk #(
  parameter  int ROWS  = 4,
  parameter  int COLS  = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int RW    = pras_pkg::addr_bits(ROWS),
  localparam int CW    = pras_pkg::addr_bits(COLS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic [CELLS-1:0] fun_d,
  input logic [CELLS-1:0] fun_q,
  input logic             capture,
  input logic             row_step,
  input logic [RW-1:0]    active_row,
  input logic [CW-1:0]    col_addr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_data,
  input logic             rd_valid,
  input logic             rd_data
);
  // R2
  func_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> fun_q == $past(fun_d));

  // R3
  func_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> active_row == '0);

  // R4
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !capture && !(wr_valid && wr_ready)) |=> $stable(fun_q));

  // R5
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && capture) |=> fun_q == $past(fun_d));

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && row_step && active_row == RW'(ROWS - 1)) |=> active_row == '0);

  // R6
  row_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && row_step && active_row != RW'(ROWS - 1)) |=>
      active_row == RW'($past(active_row) + 1'b1));

  // R7
  single_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !capture) |=> $countones(fun_q ^ $past(fun_q)) <= 1);

  // R9
  range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_addr) >= COLS) |-> (!rd_valid && !rd_data));
endmodule

bind pras_grid pras_grid_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .fun_d(fun_d),
  .fun_q(fun_q), .capture(capture), .row_step(row_step),
  .active_row(active_row), .col_addr(col_addr), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
  .rd_data(rd_data)
);

// File: tb/pras_grid_tb.sv
`timescale 1ns/1ps
module pras_grid_tb;
  localparam int ROWS = 3;
  localparam int COLS = 6;
  localparam int N    = ROWS * COLS;
  localparam int RW   = pras_pkg::addr_bits(ROWS);
  localparam int CW   = pras_pkg::addr_bits(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, capture = 1'b0, row_step = 1'b0;
  logic wr_valid = 1'b0, wr_data = 1'b0;
  logic [CW-1:0] col_addr = '0;
  logic [N-1:0]  fun_d = '0;
  logic [N-1:0]  fun_q;
  logic [RW-1:0] active_row;
  logic wr_ready, rd_valid, rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [N-1:0] mdl_q = '0;
  int           mdl_row = 0;

  logic [N-1:0] exp_q[$];
  int           exp_row[$];
  string        exp_tag[$];

  always #2.5 clk = ~clk;

  pras_grid #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .fun_d(fun_d),
    .fun_q(fun_q), .capture(capture), .row_step(row_step),
    .active_row(active_row), .col_addr(col_addr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic tm, input logic cap, input logic rs,
                      input int col, input logic wv, input logic wd,
                      input logic [N-1:0] fd, input string tag);
    bit in_rng;
    bit rdy;
    @(negedge clk);
    test_mode = tm; capture = cap; row_step = rs;
    col_addr = CW'(col); wr_valid = wv; wr_data = wd; fun_d = fd;
    #1;
    in_rng = tm && (col < COLS);
    rdy    = tm && !cap;
    check_bit({tag, " wr_ready"}, wr_ready, rdy);
    check_bit({tag, (col < COLS) ? " R8 rd_valid" : " R9 rd_valid"}, rd_valid, in_rng);
    check_bit({tag, (col < COLS) ? " R8 rd_data" : " R9 rd_data"}, rd_data,
              in_rng ? mdl_q[mdl_row*COLS + col] : 1'b0);
    if (!tm || cap) mdl_q = fd;
    else if (wv && in_rng) mdl_q[mdl_row*COLS + col] = wd;
    if (!tm) mdl_row = 0;
    else if (rs) mdl_row = (mdl_row + 1) % ROWS;
    exp_q.push_back(mdl_q);
    exp_row.push_back(mdl_row);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares one expectation per edge, one unit after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [N-1:0] eq;
        int           er;
        string        et;
        eq = exp_q.pop_front();
        er = exp_row.pop_front();
        et = exp_tag.pop_front();
        vectors++;
        if (fun_q !== eq) begin
          errors++;
          $display("FAIL %s fun_q: actual %h expected %h", et, fun_q, eq);
        end
        vectors++;
        if (int'(active_row) != er) begin
          errors++;
          $display("FAIL %s active_row: actual %0d expected %0d", et, active_row, er);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    fun_d = {N{1'b1}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1 fun_q zero", |fun_q, 1'b0);
    check_bit("R1 row zero", |active_row, 1'b0);
    rst_n = 1'b1;
    fun_d = '0;

    // R2 / R3: functional mode, writes have no effect
    step(0, 0, 0, 0, 0, 0, 18'h2A5C3, "R2 func a");
    step(0, 0, 1, 2, 1, 1, 18'h15A3C, "R3 func write ignored");
    step(0, 0, 0, 0, 0, 0, 18'h3FFFF, "R2 func ones");
    step(0, 0, 0, 0, 0, 0, 18'h00000, "R2 func zeros");

    // R4: test mode hold while fun_d moves
    step(1, 0, 0, 0, 0, 0, 18'h3FFFF, "R4 hold a");
    step(1, 0, 0, 3, 0, 1, 18'h12345, "R4 hold b");

    // R5: capture
    step(1, 1, 0, 0, 0, 0, 18'h2C6B1, "R5 capture");
    step(1, 0, 0, 0, 0, 0, 18'h00000, "R4 hold after capture");

    // R7 / R8: writes and reads in row 0
    step(1, 0, 0, 0, 1, 1, '0, "R7 write r0c0");
    step(1, 0, 0, 5, 1, 0, '0, "R7 write r0c5");
    step(1, 0, 0, 0, 0, 0, '0, "R8 read r0c0");
    step(1, 0, 0, 5, 0, 0, '0, "R8 read r0c5");

    // R6: step through rows with wrap
    step(1, 0, 1, 1, 0, 0, '0, "R6 step to 1");
    step(1, 0, 1, 1, 1, 1, '0, "R10 write r1 then step");
    step(1, 0, 0, 1, 0, 0, '0, "R8 read r2c1");
    step(1, 0, 0, 3, 1, 1, '0, "R7 write r2c3");
    step(1, 0, 1, 3, 0, 0, '0, "R6 wrap to 0");
    step(1, 0, 1, 1, 0, 0, '0, "R8 read r0c1 step");
    step(1, 0, 0, 1, 0, 0, '0, "R10 read back r1c1");

    // R9: out-of-range columns
    step(1, 0, 0, 6, 1, 1, '0, "R9 write col6");
    step(1, 0, 0, 7, 1, 0, '0, "R9 write col7");
    for (int c = 0; c < COLS; c++)
      step(1, 0, 0, c, 0, 0, '0, "R8 sweep row1");

    // R5: capture wins over write
    step(1, 1, 0, 2, 1, 1, 18'h0F0F0, "R5 capture priority");
    step(1, 0, 0, 2, 0, 0, '0, "R8 read after capture");

    // R3: leaving test mode clears row pointer
    step(1, 0, 1, 0, 0, 0, '0, "R6 step before exit");
    step(0, 0, 0, 0, 0, 0, 18'h33333, "R3 exit test mode");
    step(0, 0, 0, 0, 0, 0, 18'h0AAAA, "R2 func again");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule